// File: doc/BRIEF.md
# Flash Page Health Monitor with Refresh Scheduling

This block sits on the read path between a flash interface and the rest of a storage controller. Each page arrives as a byte stream framed by start and end markers. The stream covers the data area and the overhead area together. The block runs a 32-bit CRC over every byte of the page and compares the result with the stored check value that comes with the last byte. While the page streams in, an external BCH decoder reports how many bits it corrected in each codeword. The block adds these reports into a running total for the page.

The CRC verdict is formed first. Only a page whose CRC matches goes on to the wear check. That check compares the page's correction total with a programmable percentage of the corrector's capability, which is 96 bits per page. The parity budget that goes with this capability (13 bits per correctable bit, 1248 bits or 156 bytes) is available as a derived package constant. When the total reaches the threshold, the page's block address is placed in a small refresh queue that drops duplicates, and a level interrupt is raised. Firmware then pops the queue through a register port and schedules the erase-and-swap.

Top module: `page_health_mon`

## Requirements
- R1: The CRC is the reflected CRC-32 (polynomial 0xEDB88320, preset all ones, final inversion). It covers every byte from the start-marked byte through the end-marked byte. The result is compared with `pg_crc`, which is sampled together with the end-marked byte. Status and queue show the verdict after the second rising edge that follows the edge taking the end-marked byte.
- R2: Correction reports (`cw_valid`) add `cw_fixed` to the page total only while a page is open, from its start-marked byte through its end-marked byte. Reports outside a page are ignored. The total saturates at 1023. The total of the last finished page reads at register address 3, bits [9:0].
- R3: For a page with a matching CRC, a refresh is triggered when total*100 >= pct*96. A triggered page pushes the `pg_blk` value that was sampled with its end-marked byte.
- R4: A page with a CRC mismatch sets status bit 1. It never pushes to the queue and never raises the interrupt.
- R5: The refresh queue holds 8 entries in FIFO order. Register address 2 reads the oldest entry (0 when the queue is empty). A write to address 2 removes that entry. Status bits [11:8] give the occupancy and status bit 3 reads 1 while the queue is non-empty.
- R6: A block address already present in the queue is not added a second time.
- R7: A non-duplicate push into a full queue is dropped and sets the sticky overflow bit, status bit 2.
- R8: Every trigger sets status bit 0, including a duplicate or a dropped push. The `irq` output equals that bit. Writing 1 to any of status bits 0 to 2 clears that bit, but a set in the same cycle wins.
- R9: Register address 0 holds pct. A write of a value above 100 stores 100.
- R10: After reset, pct is 75, all status bits are 0, the queue is empty and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pg_valid | input | 1 | Page byte valid |
| pg_sop | input | 1 | First byte of a page |
| pg_eop | input | 1 | Last byte of a page |
| pg_byte | input | 8 | Page byte (data or overhead) |
| pg_blk | input | BLK_W | Block address, sampled with the last byte |
| pg_crc | input | 32 | Stored CRC, sampled with the last byte |
| cw_valid | input | 1 | Codeword correction report valid |
| cw_fixed | input | 8 | Bits corrected in that codeword |
| reg_addr | input | 2 | Register address |
| reg_wen | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Refresh interrupt, level |

## Verification
Pages of different lengths are sent with correct check values and with check values that have one bit flipped. This separates the CRC path from the wear path and shows that a bad page never reaches the queue. Correction totals are placed one below and exactly on the threshold, at both the default percentage and a clamped 100 percent, to find off-by-one errors in the comparison. Split reports, stray reports outside a page and an oversized burst show that accumulation is windowed and saturating. Repeated block addresses and a ninth distinct address show that duplicates are dropped, that overflow is recorded, and that FIFO order holds.

// File: rtl/phm_pkg.sv
package phm_pkg;
   localparam int CAP_BITS       = 96;
   localparam int PARITY_PER_BIT = 13;
   localparam int PARITY_BITS    = CAP_BITS * PARITY_PER_BIT;
   localparam int PARITY_BYTES   = (PARITY_BITS + 7) / 8;
   localparam logic [31:0] CRC_POLY = 32'hEDB88320;

   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_STAT = 2'd1;
   localparam logic [1:0] A_HEAD = 2'd2;
   localparam logic [1:0] A_SUM  = 2'd3;

   function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] d);
      logic [31:0] r;
      r = c ^ {24'h0, d};
      for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
      return r;
   endfunction
endpackage

// File: rtl/phm_crc32.sv
module phm_crc32 (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic        in_sop,
   input  logic [7:0]  in_data,
   input  logic [31:0] ref_crc,
   output logic        match
);
   import phm_pkg::*;
   logic [31:0] crc_q, crc_nxt;

   always_comb crc_nxt = crc_step(in_sop ? 32'hFFFF_FFFF : crc_q, in_data);
   assign match = (~crc_nxt == ref_crc);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        crc_q <= 32'hFFFF_FFFF;
      else if (in_valid) crc_q <= crc_nxt;
endmodule

// File: rtl/phm_accum.sv
module phm_accum #(
   parameter int SUM_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sop,
   input  logic             in_eop,
   input  logic             cw_valid,
   input  logic [7:0]       cw_fixed,
   output logic [SUM_W-1:0] sum_nxt
);
   localparam logic [SUM_W-1:0] SUM_MAX = '1;

   initial assert (SUM_W >= 8) else $error("SUM_W too small");

   logic             open_q, start, active;
   logic [SUM_W-1:0] sum_q, base;
   logic [SUM_W:0]   tmp;

   assign start  = in_valid && in_sop;
   assign active = start || open_q;

   always_comb begin
      base = start ? '0 : sum_q;
      tmp  = {1'b0, base} + ((cw_valid && active) ? (SUM_W+1)'(cw_fixed) : '0);
      sum_nxt = tmp[SUM_W] ? SUM_MAX : tmp[SUM_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         open_q <= 1'b0;
         sum_q  <= '0;
      end else begin
         if (active) sum_q <= sum_nxt;
         if (in_valid && in_eop) open_q <= 1'b0;
         else if (start)         open_q <= 1'b1;
      end

   // R2: within an open page the running total never falls
   p_sum_mono_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (open_q && !start) |=> (sum_q >= $past(sum_q)));
endmodule

// File: rtl/phm_refresh_q.sv
module phm_refresh_q #(
   parameter int BLK_W = 12,
   parameter int DEPTH = 8,
   parameter bit DEDUP = 1'b1,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [BLK_W-1:0] push_blk,
   input  logic             pop,
   output logic [BLK_W-1:0] head,
   output logic [CW-1:0]    count,
   output logic             drop
);
   initial assert (DEPTH >= 2 && (1 << PW) == DEPTH) else $error("DEPTH must be a power of two");

   logic [BLK_W-1:0] mem [DEPTH];
   logic [DEPTH-1:0] vld, match_v;
   logic [PW-1:0]    wr_p, rd_p;
   logic [CW-1:0]    cnt;
   logic             hit, full, accept, do_pop;

   generate
      if (DEDUP) begin : g_dedup
         for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
            assign match_v[i] = vld[i] && (mem[i] == push_blk);
         end
         // R6: no block address is held twice
         for (genvar i = 0; i < DEPTH; i++) begin : g_ua
            for (genvar j = i + 1; j < DEPTH; j++) begin : g_ub
               p_unique_r6: assert property (@(posedge clk) disable iff (!rst_n)
                  !(vld[i] && vld[j] && mem[i] == mem[j]));
            end
         end
      end else begin : g_nodedup
         assign match_v = '0;
      end
   endgenerate

   assign hit    = |match_v;
   assign full   = (cnt == CW'(DEPTH));
   assign accept = push && !hit && !full;
   assign drop   = push && !hit && full;
   assign do_pop = pop && (cnt != '0);
   assign head   = (cnt != '0) ? mem[rd_p] : '0;
   assign count  = cnt;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         vld  <= '0;
         wr_p <= '0;
         rd_p <= '0;
         cnt  <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (do_pop) begin
            vld[rd_p] <= 1'b0;
            rd_p      <= rd_p + 1'b1;
         end
         if (accept) begin
            mem[wr_p] <= push_blk;
            vld[wr_p] <= 1'b1;
            wr_p      <= wr_p + 1'b1;
         end
         cnt <= cnt + CW'(accept) - CW'(do_pop);
      end

   // R5: occupancy stays within depth and agrees with the slot flags
   p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
   p_count_vld_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(vld) == int'(cnt));
endmodule

// File: rtl/page_health_mon.sv
module page_health_mon #(
   parameter int BLK_W    = 12,
   parameter int QDEPTH   = 8,
   parameter int SUM_W    = 10,
   parameter int CAP      = phm_pkg::CAP_BITS,
   parameter int PCT_INIT = 75,
   parameter bit DEDUP    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pg_valid,
   input  logic             pg_sop,
   input  logic             pg_eop,
   input  logic [7:0]       pg_byte,
   input  logic [BLK_W-1:0] pg_blk,
   input  logic [31:0]      pg_crc,
   input  logic             cw_valid,
   input  logic [7:0]       cw_fixed,
   input  logic [1:0]       reg_addr,
   input  logic             reg_wen,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   output logic             irq
);
   import phm_pkg::*;
   localparam int CW = $clog2(QDEPTH + 1);
   localparam int MW = SUM_W + 8;

   initial assert (BLK_W <= 32 && SUM_W <= 24 && PCT_INIT <= 100 && CW <= 8)
      else $error("parameter out of range");

   logic             crc_ok;
   logic [SUM_W-1:0] sum_nxt;
   logic             v_done, v_ok;
   logic [SUM_W-1:0] v_sum, last_sum;
   logic [BLK_W-1:0] v_blk, q_head;
   logic [CW-1:0]    q_cnt;
   logic             q_drop, trig, pop_req;
   logic [6:0]       pct_q;
   logic             irq_q, crcerr_q, ovf_q;
   logic [MW-1:0]    lhs, rhs;
   logic             wr_stat;

   phm_crc32 u_crc (
      .clk(clk), .rst_n(rst_n), .in_valid(pg_valid), .in_sop(pg_sop),
      .in_data(pg_byte), .ref_crc(pg_crc), .match(crc_ok));

   phm_accum #(.SUM_W(SUM_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .in_valid(pg_valid), .in_sop(pg_sop),
      .in_eop(pg_eop), .cw_valid(cw_valid), .cw_fixed(cw_fixed),
      .sum_nxt(sum_nxt));

   phm_refresh_q #(.BLK_W(BLK_W), .DEPTH(QDEPTH), .DEDUP(DEDUP)) u_q (
      .clk(clk), .rst_n(rst_n), .push(trig), .push_blk(v_blk),
      .pop(pop_req), .head(q_head), .count(q_cnt), .drop(q_drop));

   // verdict stage: CRC first, wear comparison only on a clean page
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         v_done <= 1'b0;
         v_ok   <= 1'b0;
         v_sum  <= '0;
         v_blk  <= '0;
      end else begin
         v_done <= pg_valid && pg_eop;
         if (pg_valid && pg_eop) begin
            v_ok  <= crc_ok;
            v_sum <= sum_nxt;
            v_blk <= pg_blk;
         end
      end

   assign lhs  = MW'(v_sum) * MW'(100);
   assign rhs  = MW'(pct_q) * MW'(CAP);
   assign trig = v_done && v_ok && (lhs >= rhs);

   assign wr_stat = reg_wen && (reg_addr == A_STAT);
   assign pop_req = reg_wen && (reg_addr == A_HEAD);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         pct_q    <= 7'(PCT_INIT);
         irq_q    <= 1'b0;
         crcerr_q <= 1'b0;
         ovf_q    <= 1'b0;
         last_sum <= '0;
      end else begin
         if (reg_wen && reg_addr == A_CTRL)
            pct_q <= (reg_wdata > 32'd100) ? 7'd100 : reg_wdata[6:0];
         if (trig)                          irq_q <= 1'b1;
         else if (wr_stat && reg_wdata[0])  irq_q <= 1'b0;
         if (v_done && !v_ok)               crcerr_q <= 1'b1;
         else if (wr_stat && reg_wdata[1])  crcerr_q <= 1'b0;
         if (q_drop)                        ovf_q <= 1'b1;
         else if (wr_stat && reg_wdata[2])  ovf_q <= 1'b0;
         if (v_done) last_sum <= v_sum;
      end

   assign irq = irq_q;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: reg_rdata[6:0] = pct_q;
         A_STAT: begin
            reg_rdata[0]      = irq_q;
            reg_rdata[1]      = crcerr_q;
            reg_rdata[2]      = ovf_q;
            reg_rdata[3]      = (q_cnt != '0);
            reg_rdata[8 +: CW] = q_cnt;
         end
         A_HEAD:  reg_rdata[BLK_W-1:0] = q_head;
         default: reg_rdata[SUM_W-1:0] = last_sum;
      endcase
   end

   // R4: a failed CRC verdict leaves the queue untouched
   p_crcerr_no_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (v_done && !v_ok && !pop_req) |=> (q_cnt == $past(q_cnt)));
   // R8: interrupt holds until cleared
   p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !(wr_stat && reg_wdata[0])) |=> irq_q);
   // R7: overflow is sticky
   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !(wr_stat && reg_wdata[2])) |=> ovf_q);
   // R9: stored percentage never exceeds 100
   p_pct_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pct_q <= 7'd100);
endmodule

// File: tb/page_health_mon_tb_top.sv
module page_health_mon_tb_top;
   localparam int BLK_W = 12;

   logic clk = 1'b0, rst_n = 1'b0;
   logic pg_valid = 0, pg_sop = 0, pg_eop = 0;
   logic [7:0] pg_byte = '0;
   logic [BLK_W-1:0] pg_blk = '0;
   logic [31:0] pg_crc = '0;
   logic cw_valid = 0;
   logic [7:0] cw_fixed = '0;
   logic [1:0] reg_addr = '0;
   logic reg_wen = 0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic irq;

   int checks = 0, fails = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   page_health_mon dut_i (
      .clk(clk), .rst_n(rst_n), .pg_valid(pg_valid), .pg_sop(pg_sop),
      .pg_eop(pg_eop), .pg_byte(pg_byte), .pg_blk(pg_blk), .pg_crc(pg_crc),
      .cw_valid(cw_valid), .cw_fixed(cw_fixed), .reg_addr(reg_addr),
      .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

   function automatic logic [31:0] ref_crc(logic [7:0] seed, int n);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < n; i++) begin
         c = c ^ {24'h0, 8'(seed + i * 7)};
         for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
      return ~c;
   endfunction

   task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wen = 1;
      @(negedge clk);
      reg_wen = 0;
   endtask

   task automatic rd(logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   // n bytes; k reports of value v on the first k bytes; bad flips one CRC bit
   task automatic send_page(logic [BLK_W-1:0] blk, int n, int k, logic [7:0] v, bit bad);
      logic [31:0] c = ref_crc(8'(blk), n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         pg_valid = 1; pg_sop = (i == 0); pg_eop = (i == n - 1);
         pg_byte = 8'(8'(blk) + i * 7);
         pg_blk = blk; pg_crc = bad ? (c ^ 32'h0000_0100) : c;
         cw_valid = (i < k); cw_fixed = v;
      end
      @(negedge clk);
      pg_valid = 0; pg_sop = 0; pg_eop = 0; cw_valid = 0;
      @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(2'd0, d); check("R10 pct reset", d, 75);
      rd(2'd1, d); check("R10 status reset", d, 0);
      rd(2'd2, d); check("R10 head empty", d, 0);
      check("R10 irq reset", {31'b0, irq}, 0);
   endtask

   task automatic t_threshold_default;
      logic [31:0] d;
      send_page(12'd5, 16, 1, 8'd71, 0);
      rd(2'd3, d); check("R2 sum 71", d, 71);
      rd(2'd1, d); check("R3 below threshold no push", d, 0);
      send_page(12'd5, 24, 3, 8'd24, 0);
      rd(2'd3, d); check("R2 split sum 72", d, 72);
      rd(2'd1, d); check("R3 at threshold push", d, 32'h109);
      rd(2'd2, d); check("R5 head blk 5", d, 5);
      check("R8 irq pin high", {31'b0, irq}, 1);
      wr(2'd1, 32'h1);
      rd(2'd1, d); check("R8 irq cleared", d, 32'h108);
      check("R8 irq pin low", {31'b0, irq}, 0);
   endtask

   task automatic t_crc_bad;
      logic [31:0] d;
      send_page(12'd9, 20, 2, 8'd50, 1);
      rd(2'd1, d); check("R4 crc mismatch flagged no push", d, 32'h10A);
      check("R4 irq stays low", {31'b0, irq}, 0);
      rd(2'd2, d); check("R1 head unchanged", d, 5);
      wr(2'd1, 32'h2);
      rd(2'd1, d); check("R1 crc flag cleared", d, 32'h108);
   endtask

   task automatic t_dup;
      logic [31:0] d;
      send_page(12'd5, 12, 1, 8'd90, 0);
      rd(2'd1, d); check("R6 duplicate not added irq set", d, 32'h109);
      wr(2'd1, 32'h1);
   endtask

   task automatic t_window_sat;
      logic [31:0] d;
      @(negedge clk); cw_valid = 1; cw_fixed = 8'd200;
      repeat (3) @(negedge clk);
      cw_valid = 0;
      send_page(12'd11, 8, 0, 8'd0, 0);
      rd(2'd3, d); check("R2 reports outside page ignored", d, 0);
      rd(2'd1, d); check("R2 zero total no push", d, 32'h108);
      send_page(12'd12, 8, 5, 8'd255, 0);
      rd(2'd3, d); check("R2 saturate 1023", d, 1023);
      rd(2'd1, d); check("R3 saturated page pushed", d, 32'h209);
      wr(2'd1, 32'h1);
   endtask

   task automatic t_pct;
      logic [31:0] d;
      wr(2'd0, 32'd150);
      rd(2'd0, d); check("R9 clamp to 100", d, 100);
      send_page(12'd7, 10, 1, 8'd95, 0);
      rd(2'd1, d); check("R3 pct100 95 no push", d, 32'h208);
      send_page(12'd7, 30, 2, 8'd48, 0);
      rd(2'd1, d); check("R3 pct100 96 push", d, 32'h309);
      wr(2'd1, 32'h1);
      wr(2'd0, 32'd75);
      rd(2'd0, d); check("R9 write 75", d, 75);
   endtask

   task automatic t_fill;
      logic [31:0] d;
      rd(2'd2, d); check("R5 order 1st", d, 5);  wr(2'd2, 0);
      rd(2'd2, d); check("R5 order 2nd", d, 12); wr(2'd2, 0);
      rd(2'd2, d); check("R5 order 3rd", d, 7);  wr(2'd2, 0);
      rd(2'd1, d); check("R5 empty after pops", d, 0);
      for (int b = 20; b < 29; b++) send_page(12'(b), 8, 1, 8'd80, 0);
      rd(2'd1, d); check("R7 overflow set full count", d, 32'h80D);
      rd(2'd2, d); check("R5 fifo head 20", d, 20); wr(2'd2, 0);
      rd(2'd2, d); check("R5 fifo head 21", d, 21); wr(2'd2, 0);
      wr(2'd1, 32'h5);
      rd(2'd1, d); check("R7 overflow cleared", d, 32'h608);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset;
      t_threshold_default;
      t_crc_bad;
      t_dup;
      t_window_sat;
      t_pct;
      t_fill;
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule